// File: doc/BRIEF.md
# Programmable Vertical Sync Window Generator

This block produces the vertical-interval flag for an outgoing external sync signal in interlaced 525-line and 625-line video. The surrounding timing logic supplies a frame line count, two single-cycle strobes per line and a field flag. One strobe marks the start of each line and the other marks its midpoint. The block compares each strobe event against start and end positions. It derives those positions from a 2-bit start code, a 3-bit end code and the selected line standard. It raises the flag at the start position and drops it at the end position.

In the odd field, the window edges fall on whole-line boundaries. In the even field, they fall half a line later, on the midpoint of the line. In 625-line video the start can sit on lines 623 to 625 of the previous frame, so the window crosses the frame wrap. The block treats a code pair that would give a too-short window, or the reserved end code, as a configuration error and keeps the flag low. The configuration is captured once per field, so a window is never cut by a mid-field change.

Top module: `vsync_window`

## Requirements
- R1: While `rst` is high, `vint` is low at every clock. The configuration inputs are captured during reset.
- R2: `vint` changes only in the clock that follows a clock with `sol_stb` or `mid_stb` high, or when the window is blocked by a configuration error. The flag is registered, so an edge appears one clock after the strobe that causes it.
- R3: 525-line start codes 0, 1, 2 and 3 open the window at the start of odd-field line 4, 3, 2 or 1. In the even field they open it at line 266.5, 265.5, 264.5 or 263.5.
- R4: 625-line start codes 0, 1, 2 and 3 open the window at the start of line 1, 625, 624 or 623. In the even field they open it at line 313.5, 312.5, 311.5 or 310.5.
- R5: For 525-line video, end code n (0 to 6) closes the window at odd line 4+n and at even line 266.5+n.
- R6: For 625-line video, end code n (0 to 6) closes the window at odd line 1+n and at even line 313.5+n.
- R7: In a programmable mode, the configuration is illegal when the end code is 7 or when start code plus end code is below 2. An illegal configuration raises `cfg_err` and forces `vint` low one clock later. When a start and end event coincide, the end wins.
- R8: Mode values 0 and 3 ignore both codes. They use the fixed window of start code 0 and end code 2, and `cfg_err` stays low.
- R9: In 625-line video with start codes 1 to 3, the window opens on the start strobe of a line in the 623 to 625 range. It stays high across the wrap to line 1 and closes on the programmed end line.
- R10: Mode, standard and both codes are captured only in reset and in a clock where `field_even` differs from its value one clock before. The captured values govern from the next clock onward.
- R11: Integer line positions match on `sol_stb` with `line_no` equal to that line. x.5 positions match on `mid_stb` with `line_no` equal to x. `field_even` plays no part in the matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; loads configuration |
| line_no | input | 10 | Current frame line, counted from 1 |
| sol_stb | input | 1 | Start-of-line strobe, one clock |
| mid_stb | input | 1 | Mid-line strobe, one clock |
| field_even | input | 1 | Field flag, 1 in the even field |
| std625 | input | 1 | 1 selects 625-line positions, 0 selects 525-line |
| mode_sel | input | 2 | 1 or 2 enables the coded window, 0 or 3 selects the fixed window |
| start_code | input | 2 | Window start code |
| end_code | input | 3 | Window end code; 7 is reserved |
| vint | output | 1 | Vertical interval flag |
| cfg_err | output | 1 | Illegal programmed configuration |

## Verification
`vint` is due exactly one clock after the strobe that moves it. `cfg_err` reflects a new configuration one clock after the field flag toggles. `vint` is blocked one clock after that. The bench drives inputs shortly after a rising edge and samples both outputs on the falling edge. Its reference model updates on the same rising edge as the design, so every comparison falls in the cycle where the result is due. The bench spaces the strobes by idle cycles and moves the field flag only in an idle cycle, so a configuration load and a strobe never meet in one clock.

// File: rtl/vsync_window.sv
module vsync_window #(
  parameter int LW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW-1:0] line_no,
  input  logic          sol_stb,
  input  logic          mid_stb,
  input  logic          field_even,
  input  logic          std625,
  input  logic [1:0]    mode_sel,
  input  logic [1:0]    start_code,
  input  logic [2:0]    end_code,
  output logic          vint,
  output logic          cfg_err
);
  localparam logic [LW-1:0] ODD_BASE_525  = LW'(4);
  localparam logic [LW-1:0] ODD_BASE_625  = LW'(1);
  localparam logic [LW-1:0] EVEN_BASE_525 = LW'(266);
  localparam logic [LW-1:0] EVEN_BASE_625 = LW'(313);
  localparam logic [LW-1:0] WRAP_625      = LW'(626);

  logic       field_q, std_q;
  logic [1:0] mode_q, start_q;
  logic [2:0] end_q;

  always_ff @(posedge clk) begin
    if (rst || field_even != field_q) begin
      std_q   <= std625;
      mode_q  <= mode_sel;
      start_q <= start_code;
      end_q   <= end_code;
    end
    field_q <= field_even;
  end

  wire prog = (mode_q == 2'd1) || (mode_q == 2'd2);
  wire [1:0] s = prog ? start_q : 2'd0;
  wire [2:0] n = prog ? end_q : 3'd2;
  wire [3:0] gap = {2'b00, s} + {1'b0, n};

  assign cfg_err = prog && (end_q == 3'd7 || gap < 4'd2);

  wire [LW-1:0] s_w = LW'(s);
  wire [LW-1:0] n_w = LW'(n);
  wire [LW-1:0] ebase = std_q ? EVEN_BASE_625 : EVEN_BASE_525;

  wire [LW-1:0] st_odd  = std_q ? ((s == 2'd0) ? ODD_BASE_625 : WRAP_625 - s_w)
                                : ODD_BASE_525 - s_w;
  wire [LW-1:0] st_even = ebase - s_w;
  wire [LW-1:0] en_odd  = (std_q ? ODD_BASE_625 : ODD_BASE_525) + n_w;
  wire [LW-1:0] en_even = ebase + n_w;

  wire hit_set = (sol_stb && line_no == st_odd) || (mid_stb && line_no == st_even);
  wire hit_clr = (sol_stb && line_no == en_odd) || (mid_stb && line_no == en_even);

  always_ff @(posedge clk) begin
    if (rst || cfg_err) vint <= 1'b0;
    else if (hit_clr)   vint <= 1'b0;
    else if (hit_set)   vint <= 1'b1;
  end
endmodule

// File: rtl/vsync_window_chk.sv
module vsync_window_chk (
  input logic       clk,
  input logic       rst,
  input logic       sol_stb,
  input logic       mid_stb,
  input logic       field_even,
  input logic       vint,
  input logic       cfg_err,
  input logic [8:0] cfg_q
);
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst) age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R1
  reset_low_chk: assert property (@(posedge clk) rst |=> !vint);

  // R7
  err_blank_chk: assert property (@(posedge clk) disable iff (rst) cfg_err |=> !vint);

  // R2
  rise_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(vint) |-> $past(sol_stb || mid_stb));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!sol_stb && !mid_stb && !cfg_err) |=> $stable(vint));

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2 && $past(field_even) == $past(field_even, 2)) |-> $stable(cfg_q));
endmodule

bind vsync_window vsync_window_chk u_chk (
  .clk(clk), .rst(rst), .sol_stb(sol_stb), .mid_stb(mid_stb),
  .field_even(field_even), .vint(vint), .cfg_err(cfg_err),
  .cfg_q({std_q, mode_q, start_q, end_q})
);

// File: tb/vsync_window_bench.sv
module vsync_window_bench;
  logic clk = 0, rst = 1;
  logic [9:0] line_no = 10'd1;
  logic sol_stb = 0, mid_stb = 0, field_even = 0, std625 = 0;
  logic [1:0] mode_sel = 0, start_code = 0;
  logic [2:0] end_code = 0;
  logic vint, cfg_err;

  always #5 clk = ~clk;

  vsync_window u_vsync_window (.*);

  int tests = 0, fails = 0, cycles = 0;
  string cur_req = "R1";
  bit saw_wrap = 0;

  // reference model
  bit m_std, m_fq, m_vint;
  int m_mode, m_s, m_n;

  function automatic bit m_prog();
    return m_mode == 1 || m_mode == 2;
  endfunction
  function automatic bit m_err();
    return m_prog() && (m_n == 7 || m_s + m_n < 2);
  endfunction

  always @(posedge clk) begin
    int s, n, h, so, se, eo, ee;
    cycles++;
    if (rst) begin
      m_vint <= 0;
      m_std <= std625; m_mode <= mode_sel; m_s <= start_code; m_n <= end_code;
    end else begin
      if (field_even != m_fq) begin
        m_std <= std625; m_mode <= mode_sel; m_s <= start_code; m_n <= end_code;
      end
      s = m_prog() ? m_s : 0;
      n = m_prog() ? m_n : 2;
      if (m_std) begin
        so = (s == 0) ? 2 : 2 * (626 - s);
        se = 627 - 2 * s;
        eo = 2 * (1 + n);
        ee = 627 + 2 * n;
      end else begin
        so = 2 * (4 - s);
        se = 533 - 2 * s;
        eo = 2 * (4 + n);
        ee = 533 + 2 * n;
      end
      if (m_err()) m_vint <= 0;
      else if (sol_stb || mid_stb) begin
        h = sol_stb ? 2 * line_no : 2 * line_no + 1;
        if (h == eo || h == ee) m_vint <= 0;
        else if (h == so || h == se) m_vint <= 1;
      end
    end
    m_fq <= field_even;
  end

  task automatic check(string req, string what, int got, int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got %0d expected %0d (line %0d)", req, what, got, exp, line_no);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      check(cur_req, "vint", vint, m_vint);
      check(cur_req, "cfg_err", cfg_err, m_err());
      if (cur_req == "R9" && line_no == 10'd624 && vint) saw_wrap = 1;
    end
  end

  task automatic drive_line(int ln, bit s625);
    line_no = 10'(ln);
    field_even = (ln >= (s625 ? 313 : 263));
    @(posedge clk); #2 sol_stb = 1;
    @(posedge clk); #2 sol_stb = 0;
    @(posedge clk); #2 mid_stb = 1;
    @(posedge clk); #2 mid_stb = 0;
  endtask

  task automatic run_lines(bit s625, int a, int b);
    for (int ln = a; ln <= b; ln++) drive_line(ln, s625);
  endtask

  task automatic run_frames(bit s625, int k);
    for (int f = 0; f < k; f++) run_lines(s625, 1, s625 ? 625 : 525);
  endtask

  task automatic setcfg(bit s625, int md, int s, int n);
    std625 = s625; mode_sel = 2'(md); start_code = 2'(s); end_code = 3'(n);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    @(negedge clk);
    check("R1", "vint in reset", vint, 0);
    @(posedge clk); #2 rst = 0;

    cur_req = "R8";  setcfg(0, 0, 0, 7); run_frames(0, 2);
    cur_req = "R3";  setcfg(0, 1, 3, 6); run_frames(0, 2);
    cur_req = "R5";  setcfg(0, 2, 1, 4); run_frames(0, 2);
    cur_req = "R11"; setcfg(0, 1, 2, 0); run_frames(0, 2);
    cur_req = "R9";  setcfg(1, 2, 3, 6); run_frames(1, 2);
    check("R9", "window seen across wrap", saw_wrap, 1);
    cur_req = "R4";  setcfg(1, 1, 0, 2); run_frames(1, 2);
    cur_req = "R6";  setcfg(1, 2, 2, 1); run_frames(1, 2);
    cur_req = "R7";  setcfg(1, 1, 1, 7); run_frames(1, 1);
    check("R7", "cfg_err reserved end", cfg_err, 1);
    setcfg(1, 1, 1, 0); run_frames(1, 1);
    check("R7", "cfg_err short window", cfg_err, 1);
    check("R7", "vint blocked", vint, 0);
    cur_req = "R10"; setcfg(0, 1, 3, 6); run_frames(0, 1);
    check("R10", "legal after load", cfg_err, 0);
    run_lines(0, 1, 100);
    setcfg(0, 1, 3, 7);
    run_lines(0, 101, 110);
    check("R10", "mid-field change held off", cfg_err, 0);
    run_lines(0, 111, 270);
    check("R10", "change taken at field edge", cfg_err, 1);
    run_lines(0, 271, 525);
    cur_req = "R2";  setcfg(1, 3, 1, 0); run_frames(1, 2);
    check("R8", "no error in fixed mode", cfg_err, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cycles > 190000);
    tests++; fails++;
    $display("FAIL watchdog expired got %0d expected 0", cycles);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule